// File: doc/BRIEF.md
# 64-bit Rotate-and-Mask Execution Unit

This unit carries out the six rotate-left-then-mask integer operations of a 64-bit RISC pipeline. Three take their shift amount from the instruction: keep-from-boundary (clear-left), keep-up-to-boundary (clear-right) and clear-both. Two take it from a register: register clear-left and register clear-right. The sixth, mask-insert, merges the rotated source into the old destination value. The decode stage hands over the sub-opcode, the split shift and boundary fields, the record bit and three 64-bit operands. The unit rebuilds the 6-bit fields, rotates the source, forms one mask through a single shared generator, and merges.

Bits are numbered big-endian: architectural bit 0 is port bit 63 and architectural bit 63 is port bit 0. A mask from boundary `b` to end `e` sets architectural bits `b..e` when `b <= e`. When `b > e` it wraps and sets every bit except those strictly between `e` and `b`. The result and the record request are registered once, so they appear one clock after the operands are presented with `in_valid`. Reset is asynchronous, active low, and released synchronously inside the block.

Top module: `rotmask_unit`

## Requirements
- R1: The shift amount is `{sh_top, sh_field}`, so `sh_top` is amount bit 5. The mask boundary is `{mb_field, mb_low}`, so `mb_low` is boundary bit 0.
- R2: Architectural bit i is port bit 63-i. A mask (b,e) sets bits b..e when b<=e, and otherwise sets all bits except those strictly between e and b.
- R3: Sub-opcode 4'h0 (clear-left) gives rotl(src, amount) AND mask(boundary, 63). A rotation of 0 leaves the source unchanged.
- R4: Sub-opcode 4'h2 (clear-right) gives rotl(src, amount) AND mask(0, boundary), with the boundary field used as the mask end.
- R5: Sub-opcode 4'h4 (clear-both) gives rotl(src, amount) AND mask(boundary, 63-amount).
- R6: Sub-opcode 4'h6 (insert) gives (rotl(src, amount) AND m) OR (old_dst AND NOT m), where m = mask(boundary, 63-amount).
- R7: Sub-opcodes 4'h8 and 4'h9 rotate by `shreg_val[5:0]` and apply the clear-left and clear-right masks respectively. Bits 63..6 of `shreg_val` have no effect.
- R8: For the six legal sub-opcodes, `record_req` equals `rec_bit`. Any other sub-opcode gives a zero result and `record_req` low.
- R9: The result and `record_req` are updated on the clock edge that samples `in_valid` high, and `out_valid` is high for exactly that following cycle. While `in_valid` is low, the result and `record_req` hold their values.
- R10: Under reset, `out_valid`, `result` and `record_req` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands and fields are valid this cycle |
| sub_op | input | 4 | Operation select (4'h0/2/4/6/8/9) |
| sh_field | input | 5 | Shift amount bits 4..0 |
| sh_top | input | 1 | Shift amount bit 5 |
| mb_field | input | 5 | Mask boundary bits 5..1 |
| mb_low | input | 1 | Mask boundary bit 0 |
| rec_bit | input | 1 | Record bit of the instruction |
| src_val | input | 64 | Source register value |
| shreg_val | input | 64 | Shift register value (register forms) |
| old_dst | input | 64 | Old destination value (insert form) |
| out_valid | output | 1 | Result registered from the previous cycle |
| result | output | 64 | Rotated and masked result |
| record_req | output | 1 | Request for a condition-field update from the result |

## Verification
Every result and record request is due exactly one clock after the cycle in which `in_valid` is high. The bench drives operands on the falling edge, lets the next rising edge capture them, and samples `result`, `record_req` and `out_valid` on the following falling edge. It then lowers `in_valid` and changes the operands. One falling edge later it checks that the outputs held and that `out_valid` dropped.

// File: rtl/rotmask_pkg.sv
`timescale 1ns/1ps
package rotmask_pkg;

  localparam int RM_XLEN = 64;

  typedef enum logic [3:0] {
    RM_CLEAR_LEFT  = 4'h0,
    RM_CLEAR_RIGHT = 4'h2,
    RM_CLEAR_BOTH  = 4'h4,
    RM_INSERT      = 4'h6,
    RM_REG_LEFT    = 4'h8,
    RM_REG_RIGHT   = 4'h9
  } rm_op_e;

endpackage

// File: rtl/rotmask_decode.sv
`timescale 1ns/1ps
module rotmask_decode
  import rotmask_pkg::*;
#(
  parameter int XLEN = RM_XLEN
) (
  input  logic [3:0]              sub_op,
  input  logic [$clog2(XLEN)-2:0] sh_field,
  input  logic                    sh_top,
  input  logic [$clog2(XLEN)-2:0] mb_field,
  input  logic                    mb_low,
  input  logic [XLEN-1:0]         shreg,
  output logic [$clog2(XLEN)-1:0] amt,
  output logic [$clog2(XLEN)-1:0] mask_b,
  output logic [$clog2(XLEN)-1:0] mask_e,
  output logic                    legal,
  output logic                    is_insert
);
  localparam int SHW = $clog2(XLEN);
  localparam logic [SHW-1:0]  LAST     = SHW'(XLEN-1);
  localparam logic [XLEN-1:0] AMT_KEEP = XLEN'(XLEN-1);

  logic [SHW-1:0] imm_amt;
  logic [SHW-1:0] reg_amt;
  logic [SHW-1:0] bnd;

  always_comb begin
    imm_amt = {sh_top, sh_field};
    bnd     = {mb_field, mb_low};
    reg_amt = SHW'(shreg & AMT_KEEP);
  end

  always_comb begin
    amt       = '0;
    mask_b    = '0;
    mask_e    = LAST;
    legal     = 1'b1;
    is_insert = 1'b0;
    case (rm_op_e'(sub_op))
      RM_CLEAR_LEFT: begin
        amt    = imm_amt;
        mask_b = bnd;
      end
      RM_CLEAR_RIGHT: begin
        amt    = imm_amt;
        mask_e = bnd;
      end
      RM_CLEAR_BOTH: begin
        amt    = imm_amt;
        mask_b = bnd;
        mask_e = LAST - imm_amt;
      end
      RM_INSERT: begin
        amt       = imm_amt;
        mask_b    = bnd;
        mask_e    = LAST - imm_amt;
        is_insert = 1'b1;
      end
      RM_REG_LEFT: begin
        amt    = reg_amt;
        mask_b = bnd;
      end
      RM_REG_RIGHT: begin
        amt    = reg_amt;
        mask_e = bnd;
      end
      default: begin
        legal = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/rotmask_rotator.sv
`timescale 1ns/1ps
module rotmask_rotator #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0]         din,
  input  logic [$clog2(XLEN)-1:0] amt,
  output logic [XLEN-1:0]         dout
);
  localparam int SHW = $clog2(XLEN);

  logic [XLEN-1:0] stage [SHW+1];

  assign stage[0] = din;

  for (genvar k = 0; k < SHW; k++) begin : g_stage
    localparam int STEP = 1 << k;
    logic [XLEN-1:0] turned;
    // Rotation toward the MSB is rotation toward architectural bit 0.
    assign turned       = {stage[k][XLEN-1-STEP:0], stage[k][XLEN-1:XLEN-STEP]};
    assign stage[k + 1] = amt[k] ? turned : stage[k];
  end

  assign dout = stage[SHW];
endmodule

// File: rtl/rotmask_maskgen.sv
`timescale 1ns/1ps
module rotmask_maskgen #(
  parameter int XLEN = 64
) (
  input  logic [$clog2(XLEN)-1:0] mask_b,
  input  logic [$clog2(XLEN)-1:0] mask_e,
  output logic [XLEN-1:0]         mask
);
  localparam int SHW = $clog2(XLEN);
  localparam logic [SHW-1:0]  LAST = SHW'(XLEN-1);
  localparam logic [XLEN-1:0] ALL  = '1;

  logic [XLEN-1:0] tail;
  logic [XLEN-1:0] head;
  logic [SHW-1:0]  head_sh;

  always_comb begin
    // tail: architectural bits mask_b..63; head: architectural bits 0..mask_e
    head_sh = LAST - mask_e;
    tail    = ALL >> mask_b;
    head    = ALL << head_sh;
    mask    = (mask_b <= mask_e) ? (head & tail) : (head | tail);
  end
endmodule

// File: rtl/rotmask_merge.sv
`timescale 1ns/1ps
module rotmask_merge #(
  parameter int XLEN = 64
) (
  input  logic            legal,
  input  logic            is_insert,
  input  logic [XLEN-1:0] rotated,
  input  logic [XLEN-1:0] mask,
  input  logic [XLEN-1:0] old_dst,
  output logic [XLEN-1:0] merged
);
  logic [XLEN-1:0] kept;
  logic [XLEN-1:0] filler;

  always_comb begin
    kept   = rotated & mask;
    filler = is_insert ? (old_dst & ~mask) : '0;
    merged = legal ? (kept | filler) : '0;
  end
endmodule

// File: rtl/rotmask_unit.sv
`timescale 1ns/1ps
module rotmask_unit
  import rotmask_pkg::*;
#(
  parameter int XLEN = RM_XLEN
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [3:0]              sub_op,
  input  logic [$clog2(XLEN)-2:0] sh_field,
  input  logic                    sh_top,
  input  logic [$clog2(XLEN)-2:0] mb_field,
  input  logic                    mb_low,
  input  logic                    rec_bit,
  input  logic [XLEN-1:0]         src_val,
  input  logic [XLEN-1:0]         shreg_val,
  input  logic [XLEN-1:0]         old_dst,
  output logic                    out_valid,
  output logic [XLEN-1:0]         result,
  output logic                    record_req
);
  localparam int SHW = $clog2(XLEN);

  logic [1:0]      rst_pipe;
  logic            arst_sync_n;
  logic [SHW-1:0]  amt;
  logic [SHW-1:0]  mask_b;
  logic [SHW-1:0]  mask_e;
  logic            legal;
  logic            is_insert;
  logic [XLEN-1:0] rotated;
  logic [XLEN-1:0] mask;
  logic [XLEN-1:0] merged;

  logic            valid_q, valid_d;
  logic [XLEN-1:0] result_q, result_d;
  logic            rec_q, rec_d;
  logic            load_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign arst_sync_n = rst_pipe[1];

  rotmask_decode #(.XLEN(XLEN)) u_decode (
    .sub_op    (sub_op),
    .sh_field  (sh_field),
    .sh_top    (sh_top),
    .mb_field  (mb_field),
    .mb_low    (mb_low),
    .shreg     (shreg_val),
    .amt       (amt),
    .mask_b    (mask_b),
    .mask_e    (mask_e),
    .legal     (legal),
    .is_insert (is_insert)
  );

  rotmask_rotator #(.XLEN(XLEN)) u_rot (
    .din  (src_val),
    .amt  (amt),
    .dout (rotated)
  );

  rotmask_maskgen #(.XLEN(XLEN)) u_mask (
    .mask_b (mask_b),
    .mask_e (mask_e),
    .mask   (mask)
  );

  rotmask_merge #(.XLEN(XLEN)) u_merge (
    .legal     (legal),
    .is_insert (is_insert),
    .rotated   (rotated),
    .mask      (mask),
    .old_dst   (old_dst),
    .merged    (merged)
  );

  always_comb begin
    load_en  = in_valid;
    valid_d  = in_valid;
    result_d = merged;
    rec_d    = rec_bit & legal;
  end

  always_ff @(posedge clk or negedge arst_sync_n) begin
    if (!arst_sync_n) begin
      valid_q  <= 1'b0;
      result_q <= '0;
      rec_q    <= 1'b0;
    end else begin
      valid_q <= valid_d;
      if (load_en) begin
        result_q <= result_d;
        rec_q    <= rec_d;
      end
    end
  end

  assign out_valid  = valid_q;
  assign result     = result_q;
  assign record_req = rec_q;
endmodule

// File: rtl/rotmask_checker.sv
`timescale 1ns/1ps
module rotmask_checker #(
  parameter int XLEN = 64
) (
  input logic                    clk,
  input logic                    rst_sync_n,
  input logic                    in_valid,
  input logic [3:0]              sub_op,
  input logic [$clog2(XLEN)-2:0] sh_field,
  input logic                    sh_top,
  input logic [$clog2(XLEN)-2:0] mb_field,
  input logic                    mb_low,
  input logic                    rec_bit,
  input logic [XLEN-1:0]         src_val,
  input logic [XLEN-1:0]         shreg_val,
  input logic                    out_valid,
  input logic [XLEN-1:0]         result,
  input logic                    record_req
);
  localparam int SHW = $clog2(XLEN);

  logic known_op;
  logic zero_imm;
  logic [SHW-1:0] bnd;
  always_comb begin
    known_op = (sub_op == 4'h0) || (sub_op == 4'h2) || (sub_op == 4'h4) ||
               (sub_op == 4'h6) || (sub_op == 4'h8) || (sub_op == 4'h9);
    zero_imm = ({sh_top, sh_field} == '0);
    bnd      = {mb_field, mb_low};
  end

  assert_valid_follows_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_valid |=> out_valid);

  assert_valid_drops_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |=> !out_valid);

  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |=> ($stable(result) && $stable(record_req)));

  assert_unknown_op_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && !known_op) |=> (result == '0 && !record_req));

  assert_record_set_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && known_op && rec_bit) |=> record_req);

  assert_zero_rot_pass_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && sub_op == 4'h0 && zero_imm && bnd == '0) |=> (result == $past(src_val)));

  assert_last_bit_only_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && sub_op == 4'h0 && bnd == SHW'(XLEN-1)) |=> (result[XLEN-1:1] == '0));

  assert_insert_full_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && sub_op == 4'h6 && zero_imm && bnd == '0) |=> (result == $past(src_val)));

  assert_reg_amount_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && sub_op == 4'h8 && shreg_val[SHW-1:0] == '0 && bnd == '0)
      |=> (result == $past(src_val)));
endmodule

bind rotmask_unit rotmask_checker #(.XLEN(XLEN)) u_rotmask_chk (
  .clk        (clk),
  .rst_sync_n (arst_sync_n),
  .in_valid   (in_valid),
  .sub_op     (sub_op),
  .sh_field   (sh_field),
  .sh_top     (sh_top),
  .mb_field   (mb_field),
  .mb_low     (mb_low),
  .rec_bit    (rec_bit),
  .src_val    (src_val),
  .shreg_val  (shreg_val),
  .out_valid  (out_valid),
  .result     (result),
  .record_req (record_req)
);

// File: tb/sim_rotmask_unit.sv
`timescale 1ns/1ps
module sim_rotmask_unit;
  localparam int XLEN = 64;

  logic            clk;
  logic            rst_n;
  logic            in_valid;
  logic [3:0]      sub_op;
  logic [4:0]      sh_field;
  logic            sh_top;
  logic [4:0]      mb_field;
  logic            mb_low;
  logic            rec_bit;
  logic [63:0]     src_val;
  logic [63:0]     shreg_val;
  logic [63:0]     old_dst;
  logic            out_valid;
  logic [63:0]     result;
  logic            record_req;

  int  n_tests;
  int  n_fail;
  bit  done;

  rotmask_unit #(.XLEN(XLEN)) u0 (
    .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .sub_op (sub_op),
    .sh_field (sh_field), .sh_top (sh_top), .mb_field (mb_field), .mb_low (mb_low),
    .rec_bit (rec_bit), .src_val (src_val), .shreg_val (shreg_val), .old_dst (old_dst),
    .out_valid (out_valid), .result (result), .record_req (record_req)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Architectural bit i is port bit 63-i.
  function automatic logic [63:0] ref_mask(input int b, input int e);
    logic [63:0] m = '0;
    for (int i = 0; i < 64; i++) begin
      if (b <= e) begin
        if (i >= b && i <= e) m[63 - i] = 1'b1;
      end else begin
        if (i >= b || i <= e) m[63 - i] = 1'b1;
      end
    end
    return m;
  endfunction

  function automatic logic [63:0] ref_rotl(input logic [63:0] v, input int n);
    logic [63:0] r = v;
    for (int k = 0; k < n; k++) r = {r[62:0], r[63]};
    return r;
  endfunction

  function automatic logic [63:0] ref_result(input logic [3:0] op, input int sh, input int mb,
                                             input logic [63:0] s, input logic [63:0] sr,
                                             input logic [63:0] od);
    int ra = int'(sr[5:0]);
    case (op)
      4'h0: return ref_rotl(s, sh) & ref_mask(mb, 63);
      4'h2: return ref_rotl(s, sh) & ref_mask(0, mb);
      4'h4: return ref_rotl(s, sh) & ref_mask(mb, 63 - sh);
      4'h6: return (ref_rotl(s, sh) & ref_mask(mb, 63 - sh)) | (od & ~ref_mask(mb, 63 - sh));
      4'h8: return ref_rotl(s, ra) & ref_mask(mb, 63);
      4'h9: return ref_rotl(s, ra) & ref_mask(0, mb);
      default: return '0;
    endcase
  endfunction

  function automatic bit ref_legal(input logic [3:0] op);
    return (op == 4'h0) || (op == 4'h2) || (op == 4'h4) || (op == 4'h6) ||
           (op == 4'h8) || (op == 4'h9);
  endfunction

  function automatic string req_of(input logic [3:0] op);
    case (op)
      4'h0: return "R3";
      4'h2: return "R4";
      4'h4: return "R5";
      4'h6: return "R6";
      4'h8, 4'h9: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check64(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive on a falling edge, capture on the rising edge, sample one falling edge later.
  task automatic run_case(input logic [3:0] op, input int sh, input int mb, input logic rec,
                          input logic [63:0] s, input logic [63:0] sr, input logic [63:0] od,
                          input logic [63:0] exp_res, input string req);
    logic [5:0] sh6 = 6'(sh);
    logic [5:0] mb6 = 6'(mb);
    @(negedge clk);
    in_valid  = 1'b1;
    sub_op    = op;
    sh_field  = sh6[4:0];
    sh_top    = sh6[5];
    mb_field  = mb6[5:1];
    mb_low    = mb6[0];
    rec_bit   = rec;
    src_val   = s;
    shreg_val = sr;
    old_dst   = od;
    @(negedge clk);
    in_valid = 1'b0;
    check64(req, result, exp_res);
    check64("R9 out_valid", 64'(out_valid), 64'd1);
    check64("R8 record", 64'(record_req), 64'(rec & ref_legal(op)));
  endtask

  task automatic run_ref(input logic [3:0] op, input int sh, input int mb, input logic rec,
                         input logic [63:0] s, input logic [63:0] sr, input logic [63:0] od);
    run_case(op, sh, mb, rec, s, sr, od, ref_result(op, sh, mb, s, sr, od), req_of(op));
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  initial begin
    automatic logic [3:0] ops[6] = '{4'h0, 4'h2, 4'h4, 4'h6, 4'h8, 4'h9};
    logic [63:0] held;
    logic        held_rec;
    void'($urandom(32'h5EED_0042));
    n_tests = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; in_valid = 1'b0; sub_op = '0; sh_field = '0; sh_top = 1'b0;
    mb_field = '0; mb_low = 1'b0; rec_bit = 1'b0; src_val = '0; shreg_val = '0; old_dst = '0;
    repeat (3) @(negedge clk);
    // R10: reset state
    check64("R10 out_valid", 64'(out_valid), 64'd0);
    check64("R10 result", result, 64'd0);
    check64("R10 record", 64'(record_req), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: sh_top is amount bit 5; mb_low is boundary bit 0
    run_case(4'h0, 32, 0, 1'b0, 64'h1, '0, '0, 64'h1_0000_0000, "R1 sh_top");
    run_case(4'h0, 0, 1, 1'b0, '1, '0, '0, 64'h7FFF_FFFF_FFFF_FFFF, "R1 mb_low");
    // R2: bit numbering and wrap-around mask
    run_case(4'h2, 0, 0, 1'b0, '1, '0, '0, 64'h8000_0000_0000_0000, "R2 bit0 is MSB");
    run_case(4'h4, 10, 60, 1'b0, '1, '0, '0, 64'hFFFF_FFFF_FFFF_FC0F, "R2 wrap mask");
    // R3: zero rotation passes through
    run_case(4'h0, 0, 0, 1'b1, 64'hDEAD_BEEF_0123_4567, '0, '0, 64'hDEAD_BEEF_0123_4567, "R3 zero rotate");
    // R8: unrecognised sub-opcode
    run_case(4'h1, 5, 5, 1'b1, '1, '1, '1, 64'd0, "R8 illegal op");
    run_case(4'hF, 0, 0, 1'b1, '1, '1, '1, 64'd0, "R8 illegal op");
    // R7: upper shift register bits ignored
    run_case(4'h8, 0, 0, 1'b0, 64'h0123_4567_89AB_CDEF, 64'hFFFF_FFFF_FFFF_FFC0, '0,
             64'h0123_4567_89AB_CDEF, "R7 upper bits ignored");

    // Every form, every shift amount, plus boundary corners
    foreach (ops[j]) begin
      for (int sh = 0; sh < 64; sh++) begin
        run_ref(ops[j], sh, int'($urandom_range(63)), 1'($urandom()), rnd64(),
                {rnd64() & 64'hFFFF_FFFF_FFFF_FFC0} | 64'(sh), rnd64());
      end
      run_ref(ops[j], 0, 0, 1'b0, rnd64(), rnd64(), rnd64());
      run_ref(ops[j], 0, 63, 1'b1, rnd64(), rnd64(), rnd64());
      run_ref(ops[j], 63, 0, 1'b1, rnd64(), rnd64(), rnd64());
      run_ref(ops[j], 63, 63, 1'b0, rnd64(), rnd64(), rnd64());
      run_ref(ops[j], 17, 0, 1'b0, rnd64(), 64'd0, rnd64());
    end

    // Random mix
    for (int t = 0; t < 400; t++) begin
      automatic logic [3:0] op = ops[$urandom_range(5)];
      run_ref(op, int'($urandom_range(63)), int'($urandom_range(63)), 1'($urandom()),
              rnd64(), rnd64(), rnd64());
    end

    // R9: hold while idle
    run_ref(4'h6, 12, 9, 1'b1, 64'hA5A5_5A5A_F00F_0FF0, '0, 64'h1111_2222_3333_4444);
    held     = result;
    held_rec = record_req;
    @(negedge clk);
    sub_op = 4'h0; src_val = '1; rec_bit = 1'b0; sh_field = 5'd3; old_dst = '0;
    @(negedge clk);
    check64("R9 hold result", result, held);
    check64("R9 hold record", 64'(record_req), 64'(held_rec));
    check64("R9 out_valid low", 64'(out_valid), 64'd0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule